// File: doc/BRIEF.md
# JTAG Test Access Port with Multi-Chain Data Register Decode

This block is a boundary-scan test access port. It is clocked by the test clock and steered by the mode-select input, and an asynchronous active-low test reset overrides both. The standard sixteen-state controller decides, from the sequence of mode-select values seen on rising test-clock edges, whether the instruction path or a data path is in use. It also decides when that path captures parallel data, shifts serially from the data input toward the data output, and loads its parallel update register.

A 4-bit instruction register holds the active opcode. That opcode selects exactly one of six data chains: a one-bit bypass, a boundary chain of configurable length, a 32-bit device identifier, and three 35-bit debug-access chains. The three debug-access chains are abort, debug-port access and access-port access. Each debug-access chain captures its value from an input port and presents its updated value on an output port, with a one-cycle strobe per update. An opcode that is not implemented falls back to the bypass chain, so the serial path always stays connected. The two boundary-drive opcodes freeze every data chain. Serial output changes on falling test-clock edges and is enabled only while shifting.

Top module: `scan_tap_top`

## Requirements
- R1: The controller moves between the sixteen standard states on each rising edge of `tck`, using the `tms` value sampled at that edge. Five consecutive rising edges with `tms` = 1 reach Test-Logic-Reset from any state. While in Test-Logic-Reset, the instruction update register loads the IDCODE opcode 4'hE on the falling edge.
- R2: Driving `trst_n` low at any time, without a clock edge, puts the controller in Test-Logic-Reset and the instruction register at 4'hE. The same action clears all update outputs and strobes, and forces `tdo_o` and `tdo_en_o` to 0.
- R3: In Capture-IR the instruction shift register loads the pattern 4'b0001. Instruction bits shift in LSB first, so the first bit appearing on `tdo_o` during Shift-IR is 1.
- R4: The opcode encoding is: 4'h0 EXTEST, 4'h1 INTEST, 4'h2 boundary scan, 4'h8 abort, 4'hA debug-port access, 4'hB access-port access, 4'hE IDCODE and 4'hF bypass. Every other opcode selects the bypass chain. The bypass chain is one bit and captures 0, so a DR scan of n bits returns 0 followed by the first n-1 input bits.
- R5: With IDCODE selected, a 32-bit DR scan returns the `IDCODE_VAL` parameter, least significant bit first.
- R6: The abort, debug-port access and access-port access chains are each 35 bits. In Capture-DR each loads from its own `*_cap_i` port, and a DR scan returns that value LSB first. On the falling edge in Update-DR each loads its shifted value onto its own `*_upd_o` port.
- R7: The boundary chain has `BSR_LEN` bits. It captures `bsr_cap_i` in Capture-DR and loads `bsr_upd_o` on the falling edge in Update-DR.
- R8: While EXTEST or INTEST is active, a DR scan captures, shifts and updates no chain. `bsr_upd_o` and all other update outputs keep their values, no data update strobe is raised, and `tdo_o` presents bit 0 of the held boundary chain throughout Shift-DR.
- R9: `tdo_o` and `tdo_en_o` change only on falling edges of `tck`. `tdo_en_o` is 1 only after a falling edge in Shift-IR or Shift-DR. In every other state both outputs are 0.
- R10: `ir_upd_stb_o` is high for one `tck` period after the falling edge in Update-IR. `dr_upd_stb_o` raises one bit for one period after the falling edge in Update-DR, for the chain that was updated: bit 0 boundary, bit 1 abort, bit 2 debug-port access, bit 3 access-port access. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en_o | output | 1 | High while serial output is valid (shift states) |
| bsr_cap_i | input | BSR_LEN | Parallel value captured by the boundary chain |
| bsr_upd_o | output | BSR_LEN | Boundary chain update register |
| abort_cap_i | input | 35 | Parallel value captured by the abort chain |
| abort_upd_o | output | 35 | Abort chain update register |
| dpacc_cap_i | input | 35 | Parallel value captured by the debug-port access chain |
| dpacc_upd_o | output | 35 | Debug-port access chain update register |
| apacc_cap_i | input | 35 | Parallel value captured by the access-port access chain |
| apacc_upd_o | output | 35 | Access-port access chain update register |
| ir_upd_stb_o | output | 1 | One-period strobe after an instruction update |
| dr_upd_stb_o | output | 4 | One-period strobe per updated data chain |

## Verification
Each TDO bit is produced on the falling edge that follows the rising edge that shifted it, and the bench reads it one time unit after that falling edge, just before the next rising edge. Update outputs are valid after the falling edge inside Update-DR or Update-IR, so the bench compares them once the scan task has passed that edge. Strobes stay high through the following Run-Test/Idle period, and a counter sampling on rising edges records them, so each strobe count is compared after the Run-Test/Idle cycle completes. The asynchronous reset is checked two time units after `trst_n` falls, with the clock held low, so no edge can account for the result.

// File: rtl/scan_tap_pkg.sv
// Shared definitions for the test access port: controller states, opcode
// encoding, chain identifiers and the pure next-state / decode functions.
// Assumes a 4-bit instruction register; all other widths derive from here.
package scan_tap_pkg;

    localparam int IR_W    = 4;
    localparam int DBG_W   = 35;
    localparam int ID_W    = 32;
    localparam int NUM_DBG = 3;
    localparam int NUM_DR_STB = NUM_DBG + 1;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

    localparam logic [IR_W-1:0] OP_EXTEST   = 4'h0;
    localparam logic [IR_W-1:0] OP_INTEST   = 4'h1;
    localparam logic [IR_W-1:0] OP_BOUNDARY = 4'h2;
    localparam logic [IR_W-1:0] OP_ABORT    = 4'h8;
    localparam logic [IR_W-1:0] OP_DPACC    = 4'hA;
    localparam logic [IR_W-1:0] OP_APACC    = 4'hB;
    localparam logic [IR_W-1:0] OP_IDCODE   = 4'hE;
    localparam logic [IR_W-1:0] OP_BYPASS   = 4'hF;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SHIFT_DR, S_EXIT1_DR, S_PAUSE_DR, S_EXIT2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SHIFT_IR, S_EXIT1_IR, S_PAUSE_IR, S_EXIT2_IR, S_UPD_IR
    } tap_state_e;

    // CH_HOLD: boundary-drive instructions; no chain moves.
    typedef enum logic [2:0] {
        CH_BYPASS, CH_BOUND, CH_IDCODE, CH_ABORT, CH_DPACC, CH_APACC, CH_HOLD
    } chain_e;

    // Next controller state for a given mode-select bit.
    function automatic tap_state_e tap_next(input tap_state_e cur, input logic sel);
        tap_state_e nxt;
        case (cur)
            S_TLR:      nxt = sel ? S_TLR      : S_RTI;
            S_RTI:      nxt = sel ? S_SEL_DR   : S_RTI;
            S_SEL_DR:   nxt = sel ? S_SEL_IR   : S_CAP_DR;
            S_CAP_DR:   nxt = sel ? S_EXIT1_DR : S_SHIFT_DR;
            S_SHIFT_DR: nxt = sel ? S_EXIT1_DR : S_SHIFT_DR;
            S_EXIT1_DR: nxt = sel ? S_UPD_DR   : S_PAUSE_DR;
            S_PAUSE_DR: nxt = sel ? S_EXIT2_DR : S_PAUSE_DR;
            S_EXIT2_DR: nxt = sel ? S_UPD_DR   : S_SHIFT_DR;
            S_UPD_DR:   nxt = sel ? S_SEL_DR   : S_RTI;
            S_SEL_IR:   nxt = sel ? S_TLR      : S_CAP_IR;
            S_CAP_IR:   nxt = sel ? S_EXIT1_IR : S_SHIFT_IR;
            S_SHIFT_IR: nxt = sel ? S_EXIT1_IR : S_SHIFT_IR;
            S_EXIT1_IR: nxt = sel ? S_UPD_IR   : S_PAUSE_IR;
            S_PAUSE_IR: nxt = sel ? S_EXIT2_IR : S_PAUSE_IR;
            S_EXIT2_IR: nxt = sel ? S_UPD_IR   : S_SHIFT_IR;
            S_UPD_IR:   nxt = sel ? S_SEL_DR   : S_RTI;
            default:    nxt = S_TLR;
        endcase
        return nxt;
    endfunction

    // Map an opcode to the data chain it selects; unknown codes go to bypass.
    function automatic chain_e decode_op(input logic [IR_W-1:0] op);
        chain_e ch;
        case (op)
            OP_EXTEST, OP_INTEST: ch = CH_HOLD;
            OP_BOUNDARY:          ch = CH_BOUND;
            OP_IDCODE:            ch = CH_IDCODE;
            OP_ABORT:             ch = CH_ABORT;
            OP_DPACC:             ch = CH_DPACC;
            OP_APACC:             ch = CH_APACC;
            default:              ch = CH_BYPASS;
        endcase
        return ch;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test access port controller.
// Assumes: tms is stable around the rising edge of tck; trst_n may fall at
// any time and forces Test-Logic-Reset without a clock.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    // State register: advance on rising tck, asynchronous reset to TLR.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_o <= S_TLR;
        end else begin
            state_o <= tap_next(state_o, tms);
        end
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction path: a shift register that captures a fixed pattern and
// shifts LSB first on rising tck, plus an update register that loads on
// falling tck. Assumes phase flags are decoded from the controller state.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture_i,
    input  logic            shift_i,
    input  logic            update_i,
    input  logic            in_reset_i,
    output logic [IR_W-1:0] ir_o,
    output logic            so_o,
    output logic            stb_o
);

    logic [IR_W-1:0] sr_q;

    // Shift stage: capture the fixed pattern or shift one bit toward so_o.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= IR_CAPTURE_PAT;
        end else if (capture_i) begin
            sr_q <= IR_CAPTURE_PAT;
        end else if (shift_i) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    // Update stage: load on falling tck; TLR forces the identifier opcode.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_o  <= OP_IDCODE;
            stb_o <= 1'b0;
        end else if (in_reset_i) begin
            ir_o  <= OP_IDCODE;
            stb_o <= 1'b0;
        end else if (update_i) begin
            ir_o  <= sr_q;
            stb_o <= 1'b1;
        end else begin
            stb_o <= 1'b0;
        end
    end

    assign so_o = sr_q[0];

endmodule

// File: rtl/scan_tap_chain.sv
// Generic data chain with parallel capture, serial shift and a falling-edge
// update register plus a one-period update strobe. Acts only when sel_i is
// high. Assumes capture, shift and update flags are mutually exclusive.
module scan_tap_chain #(
    parameter int WIDTH = 8
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sel_i,
    input  logic             capture_i,
    input  logic             shift_i,
    input  logic             update_i,
    input  logic             tdi,
    input  logic [WIDTH-1:0] cap_i,
    output logic             so_o,
    output logic [WIDTH-1:0] par_o,
    output logic             stb_o
);

    logic [WIDTH-1:0] sr_q;

    generate
        if (WIDTH == 1) begin : g_single
            // Shift stage for a one-bit chain.
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    sr_q <= '0;
                end else if (sel_i && capture_i) begin
                    sr_q <= cap_i;
                end else if (sel_i && shift_i) begin
                    sr_q <= tdi;
                end
            end
        end else begin : g_multi
            // Shift stage: capture parallel input or shift toward bit 0.
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    sr_q <= '0;
                end else if (sel_i && capture_i) begin
                    sr_q <= cap_i;
                end else if (sel_i && shift_i) begin
                    sr_q <= {tdi, sr_q[WIDTH-1:1]};
                end
            end
        end
    endgenerate

    // Update stage: load parallel register and pulse strobe on falling tck.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            par_o <= '0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= sel_i && update_i;
            if (sel_i && update_i) begin
                par_o <= sr_q;
            end
        end
    end

    assign so_o = sr_q[0];

endmodule

// File: rtl/scan_tap_top.sv
// Test access port top: controller, instruction path, bypass, identifier,
// boundary and three debug-access chains, and the falling-edge TDO stage.
// Assumes IDCODE_VAL has bit 0 set. Unimplemented opcodes route bypass;
// boundary-drive opcodes freeze all chains and present boundary bit 0.
module scan_tap_top
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN    = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h1A5C_3E2B
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo_o,
    output logic               tdo_en_o,
    input  logic [BSR_LEN-1:0] bsr_cap_i,
    output logic [BSR_LEN-1:0] bsr_upd_o,
    input  logic [DBG_W-1:0]   abort_cap_i,
    output logic [DBG_W-1:0]   abort_upd_o,
    input  logic [DBG_W-1:0]   dpacc_cap_i,
    output logic [DBG_W-1:0]   dpacc_upd_o,
    input  logic [DBG_W-1:0]   apacc_cap_i,
    output logic [DBG_W-1:0]   apacc_upd_o,
    output logic               ir_upd_stb_o,
    output logic [NUM_DR_STB-1:0] dr_upd_stb_o
);

    tap_state_e state_q;
    logic       cap_ir, shift_ir, upd_ir, cap_dr, shift_dr, upd_dr, in_tlr;
    logic [IR_W-1:0] ir_val;
    logic       ir_so;
    chain_e     chain;

    logic                          bypass_q;
    logic [ID_W-1:0]               id_sr_q;
    logic                          bnd_so, bnd_stb;
    logic [NUM_DBG-1:0]            dbg_sel, dbg_so, dbg_stb;
    logic [NUM_DBG-1:0][DBG_W-1:0] dbg_cap, dbg_par;
    logic                          dr_so;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state_q)
    );

    // Phase flags decoded from the controller state.
    always_comb begin
        cap_ir   = (state_q == S_CAP_IR);
        shift_ir = (state_q == S_SHIFT_IR);
        upd_ir   = (state_q == S_UPD_IR);
        cap_dr   = (state_q == S_CAP_DR);
        shift_dr = (state_q == S_SHIFT_DR);
        upd_dr   = (state_q == S_UPD_DR);
        in_tlr   = (state_q == S_TLR);
    end

    scan_tap_ir u_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .capture_i  (cap_ir),
        .shift_i    (shift_ir),
        .update_i   (upd_ir),
        .in_reset_i (in_tlr),
        .ir_o       (ir_val),
        .so_o       (ir_so),
        .stb_o      (ir_upd_stb_o)
    );

    assign chain = decode_op(ir_val);

    // Bypass chain: one bit, captures zero.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            bypass_q <= 1'b0;
        end else if (chain == CH_BYPASS && cap_dr) begin
            bypass_q <= 1'b0;
        end else if (chain == CH_BYPASS && shift_dr) begin
            bypass_q <= tdi;
        end
    end

    // Identifier chain: captures the constant, shifts LSB first, no update.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sr_q <= IDCODE_VAL;
        end else if (chain == CH_IDCODE && cap_dr) begin
            id_sr_q <= IDCODE_VAL;
        end else if (chain == CH_IDCODE && shift_dr) begin
            id_sr_q <= {tdi, id_sr_q[ID_W-1:1]};
        end
    end

    scan_tap_chain #(.WIDTH(BSR_LEN)) u_bnd (
        .tck       (tck),
        .trst_n    (trst_n),
        .sel_i     (chain == CH_BOUND),
        .capture_i (cap_dr),
        .shift_i   (shift_dr),
        .update_i  (upd_dr),
        .tdi       (tdi),
        .cap_i     (bsr_cap_i),
        .so_o      (bnd_so),
        .par_o     (bsr_upd_o),
        .stb_o     (bnd_stb)
    );

    assign dbg_sel = {chain == CH_APACC, chain == CH_DPACC, chain == CH_ABORT};
    assign dbg_cap = {apacc_cap_i, dpacc_cap_i, abort_cap_i};

    generate
        for (genvar g = 0; g < NUM_DBG; g++) begin : g_dbg
            scan_tap_chain #(.WIDTH(DBG_W)) u_chain (
                .tck       (tck),
                .trst_n    (trst_n),
                .sel_i     (dbg_sel[g]),
                .capture_i (cap_dr),
                .shift_i   (shift_dr),
                .update_i  (upd_dr),
                .tdi       (tdi),
                .cap_i     (dbg_cap[g]),
                .so_o      (dbg_so[g]),
                .par_o     (dbg_par[g]),
                .stb_o     (dbg_stb[g])
            );
        end
    endgenerate

    assign abort_upd_o  = dbg_par[0];
    assign dpacc_upd_o  = dbg_par[1];
    assign apacc_upd_o  = dbg_par[2];
    assign dr_upd_stb_o = {dbg_stb, bnd_stb};

    // Data-path serial output chosen by the active instruction.
    always_comb begin
        case (chain)
            CH_BOUND, CH_HOLD: dr_so = bnd_so;
            CH_IDCODE:         dr_so = id_sr_q[0];
            CH_ABORT:          dr_so = dbg_so[0];
            CH_DPACC:          dr_so = dbg_so[1];
            CH_APACC:          dr_so = dbg_so[2];
            default:           dr_so = bypass_q;
        endcase
    end

    // Output stage: present the shifting path on falling tck, idle low.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_o    <= 1'b0;
            tdo_en_o <= 1'b0;
        end else if (shift_ir) begin
            tdo_o    <= ir_so;
            tdo_en_o <= 1'b1;
        end else if (shift_dr) begin
            tdo_o    <= dr_so;
            tdo_en_o <= 1'b1;
        end else begin
            tdo_o    <= 1'b0;
            tdo_en_o <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_tap_checker.sv
// Temporal checks for scan_tap_top, attached by bind below. Observes the
// controller state and active opcode alongside the block's outputs.
module scan_tap_checker
    import scan_tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic                  tck,
    input logic                  trst_n,
    input logic                  tms,
    input tap_state_e            state,
    input logic [IR_W-1:0]       ir_val,
    input logic                  tdo_o,
    input logic                  tdo_en_o,
    input logic                  ir_upd_stb_o,
    input logic [NUM_DR_STB-1:0] dr_upd_stb_o,
    input logic [BSR_LEN-1:0]    bsr_upd_o
);

    logic [2:0] ones_cnt;
    logic       hold_op;

    // Count consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ones_cnt <= '0;
        end else if (!tms) begin
            ones_cnt <= '0;
        end else if (ones_cnt < 3'd5) begin
            ones_cnt <= ones_cnt + 3'd1;
        end
    end

    assign hold_op = (ir_val == OP_EXTEST) || (ir_val == OP_INTEST);

    assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 3'd5) |-> (state == S_TLR));

    assert_hold_no_strobe_R8: assert property (@(posedge tck) disable iff (!trst_n)
        hold_op |-> (dr_upd_stb_o == '0));

    assert_hold_bsr_stable_R8: assert property (@(posedge tck) disable iff (!trst_n)
        hold_op |=> $stable(bsr_upd_o));

    assert_tdo_en_shift_only_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en_o |-> (state == S_SHIFT_DR || state == S_SHIFT_IR));

    assert_tdo_idle_low_R9: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en_o |-> !tdo_o);

    assert_ir_strobe_state_R10: assert property (@(posedge tck) disable iff (!trst_n)
        ir_upd_stb_o |-> (state == S_UPD_IR));

    assert_dr_strobe_state_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_upd_stb_o != '0) |-> (state == S_UPD_DR));

    assert_strobe_onehot_R10: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({ir_upd_stb_o, dr_upd_stb_o}));

    assert_dr_strobe_single_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_upd_stb_o != '0) |=> (dr_upd_stb_o == '0));

endmodule

bind scan_tap_top scan_tap_checker #(.BSR_LEN(BSR_LEN)) u_checker (
    .tck          (tck),
    .trst_n       (trst_n),
    .tms          (tms),
    .state        (state_q),
    .ir_val       (ir_val),
    .tdo_o        (tdo_o),
    .tdo_en_o     (tdo_en_o),
    .ir_upd_stb_o (ir_upd_stb_o),
    .dr_upd_stb_o (dr_upd_stb_o),
    .bsr_upd_o    (bsr_upd_o)
);

// File: tb/scan_tap_top_bench.sv
module scan_tap_top_bench;

    localparam int          TCK_PERIOD = 20;
    localparam int          HALF       = TCK_PERIOD / 2;
    localparam int          BSR_LEN    = 8;
    localparam int          DW         = 35;
    localparam logic [31:0] ID_VAL     = 32'h1A5C_3E2B;

    logic tck = 1'b0, trst_n = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, ir_stb;
    logic [3:0] dr_stb;
    logic [BSR_LEN-1:0] bsr_cap, bsr_upd;
    logic [DW-1:0] abort_cap, abort_upd, dpacc_cap, dpacc_upd, apacc_cap, apacc_upd;

    // Debug-port logic stand-in: access chains read back what was written.
    assign dpacc_cap = dpacc_upd;
    assign apacc_cap = apacc_upd;

    int checks = 0, errors = 0;
    int stb_cnt [4];
    int ir_cnt = 0;

    scan_tap_top #(.BSR_LEN(BSR_LEN), .IDCODE_VAL(ID_VAL)) u_scan_tap_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo_o(tdo), .tdo_en_o(tdo_en),
        .bsr_cap_i(bsr_cap), .bsr_upd_o(bsr_upd),
        .abort_cap_i(abort_cap), .abort_upd_o(abort_upd),
        .dpacc_cap_i(dpacc_cap), .dpacc_upd_o(dpacc_upd),
        .apacc_cap_i(apacc_cap), .apacc_upd_o(apacc_upd),
        .ir_upd_stb_o(ir_stb), .dr_upd_stb_o(dr_stb)
    );

    initial for (int i = 0; i < 4; i++) stb_cnt[i] = 0;

    always @(posedge tck) begin
        for (int i = 0; i < 4; i++) if (dr_stb[i]) stb_cnt[i]++;
        if (ir_stb) ir_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One tck period: sample tdo after the last falling edge, drive, pulse.
    task automatic clk1(input logic m, input logic d, output logic so, output logic en);
        #1;
        so = tdo; en = tdo_en;
        tms = m; tdi = d;
        #(HALF - 1) tck = 1'b1;
        #(HALF) tck = 1'b0;
    endtask

    task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
        logic s, e;
        clk1(1, 0, s, e); clk1(1, 0, s, e); clk1(0, 0, s, e); clk1(0, 0, s, e);
        for (int i = 0; i < 4; i++) begin
            clk1(i == 3, op[i], s, e);
            cap[i] = s;
        end
        clk1(1, 0, s, e); clk1(0, 0, s, e);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output bit en_ok);
        logic s, e;
        dout = '0; en_ok = 1'b1;
        clk1(1, 0, s, e); clk1(0, 0, s, e); clk1(0, 0, s, e);
        for (int i = 0; i < n; i++) begin
            clk1(i == n - 1, din[i], s, e);
            dout[i] = s;
            if (!e) en_ok = 1'b0;
        end
        clk1(1, 0, s, e); clk1(0, 0, s, e);
    endtask

    function automatic logic [63:0] mask_of(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [63:0] bypass_exp(input int n, input logic [63:0] din);
        return (din << 1) & mask_of(n);
    endfunction

    initial begin
        #(TCK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  irc;
        logic [63:0] dout, w, w2, v, din;
        logic [DW-1:0] exp_dp, exp_ap;
        logic [3:0] unimpl [8];
        bit en;
        int s0, s1, s2, s3, n;
        logic s, e;
        unimpl = '{4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h9, 4'hC, 4'hD};
        void'($urandom(32'h0005EED1));
        bsr_cap = '0; abort_cap = '0;

        // R2: asynchronous reset, clock idle
        #2 trst_n = 1'b0;
        #(TCK_PERIOD);
        check(tdo_en === 1'b0 && tdo === 1'b0, "R2 reset tdo idle", 64'({tdo_en, tdo}), 64'd0);
        check(dpacc_upd === '0 && abort_upd === '0 && apacc_upd === '0 && bsr_upd === '0,
              "R2 reset update regs", 64'(dpacc_upd), 64'd0);
        check({ir_stb, dr_stb} === 5'd0, "R10 reset strobes", 64'({ir_stb, dr_stb}), 64'd0);
        trst_n = 1'b1;
        #(HALF);
        clk1(0, 0, s, e);

        // R5: identifier readout after reset; R9 enable only while shifting
        shift_dr(32, 64'd0, dout, en);
        check(dout[31:0] === ID_VAL, "R5 idcode readout", dout, 64'(ID_VAL));
        check(en, "R9 tdo_en high in Shift-DR", 64'(en), 64'd1);
        #1 check(tdo_en === 1'b0 && tdo === 1'b0, "R9 tdo idle in RTI", 64'({tdo_en, tdo}), 64'd0);

        // R3 capture pattern, R10 IR strobe count
        s0 = ir_cnt;
        shift_ir(4'hF, irc);
        check(irc === 4'b0001, "R3 IR capture pattern", 64'(irc), 64'd1);
        check(ir_cnt == s0 + 1, "R10 one IR strobe", 64'(ir_cnt - s0), 64'd1);

        // R4 bypass one-cycle delay
        din = rnd64() & mask_of(20);
        shift_dr(20, din, dout, en);
        check(dout === bypass_exp(20, din), "R4 bypass delay", dout, bypass_exp(20, din));
        foreach (unimpl[k]) begin
            shift_ir(unimpl[k], irc);
            din = rnd64() & mask_of(12);
            shift_dr(12, din, dout, en);
            check(dout === bypass_exp(12, din), "R4 unimplemented opcode bypass", dout, bypass_exp(12, din));
        end

        // R6 debug-port write then readback, R10 strobes
        shift_ir(4'hA, irc);
        s0 = stb_cnt[0]; s1 = stb_cnt[1]; s2 = stb_cnt[2]; s3 = stb_cnt[3];
        w = rnd64() & mask_of(DW);
        shift_dr(DW, w, dout, en);
        check(64'(dpacc_upd) === w, "R6 dpacc write", 64'(dpacc_upd), w);
        check(stb_cnt[2] == s2 + 1, "R10 dpacc strobe once", 64'(stb_cnt[2] - s2), 64'd1);
        check(stb_cnt[0] == s0 && stb_cnt[1] == s1 && stb_cnt[3] == s3, "R10 other strobes quiet",
              64'(stb_cnt[0] + stb_cnt[1] + stb_cnt[3]), 64'(s0 + s1 + s3));
        w2 = rnd64() & mask_of(DW);
        shift_dr(DW, w2, dout, en);
        check(dout === w, "R6 dpacc readback", dout, w);
        check(64'(dpacc_upd) === w2, "R6 dpacc second write", 64'(dpacc_upd), w2);
        exp_dp = w2[DW-1:0];

        // R6 abort chain captures its port
        abort_cap = DW'(rnd64());
        shift_ir(4'h8, irc);
        w = rnd64() & mask_of(DW);
        shift_dr(DW, w, dout, en);
        check(dout === 64'(abort_cap), "R6 abort capture", dout, 64'(abort_cap));
        check(64'(abort_upd) === w, "R6 abort update", 64'(abort_upd), w);

        // R6 access-port chain
        shift_ir(4'hB, irc);
        w = rnd64() & mask_of(DW);
        shift_dr(DW, w, dout, en);
        check(64'(apacc_upd) === w, "R6 apacc update", 64'(apacc_upd), w);
        exp_ap = w[DW-1:0];

        // R7 boundary chain
        bsr_cap = BSR_LEN'($urandom());
        shift_ir(4'h2, irc);
        v = 64'hA5;
        shift_dr(BSR_LEN, v, dout, en);
        check(dout === 64'(bsr_cap), "R7 boundary capture", dout, 64'(bsr_cap));
        check(64'(bsr_upd) === v, "R7 boundary update", 64'(bsr_upd), v);

        // R8 EXTEST and INTEST freeze all chains
        for (int k = 0; k < 2; k++) begin
            shift_ir(k == 0 ? 4'h0 : 4'h1, irc);
            bsr_cap = ~bsr_cap;
            s0 = stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3];
            din = rnd64() & mask_of(BSR_LEN);
            shift_dr(BSR_LEN, din, dout, en);
            check(dout === mask_of(BSR_LEN) * 64'(v[0]), "R8 tdo holds boundary bit0", dout,
                  mask_of(BSR_LEN) * 64'(v[0]));
            check(64'(bsr_upd) === v, "R8 boundary update unchanged", 64'(bsr_upd), v);
            check(dpacc_upd === exp_dp, "R8 dpacc unchanged", 64'(dpacc_upd), 64'(exp_dp));
            check(stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3] == s0, "R8 no data strobe",
                  64'(stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3] - s0), 64'd0);
        end

        // Random mix over access chains and bypass
        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = int'($urandom() % 5);
            w = rnd64() & mask_of(DW);
            case (kind)
                0: begin
                    abort_cap = DW'(rnd64());
                    shift_ir(4'h8, irc);
                    shift_dr(DW, w, dout, en);
                    check(dout === 64'(abort_cap), "R6 random abort capture", dout, 64'(abort_cap));
                    check(64'(abort_upd) === w, "R6 random abort update", 64'(abort_upd), w);
                end
                1: begin
                    shift_ir(4'hA, irc);
                    shift_dr(DW, w, dout, en);
                    check(dout === 64'(exp_dp), "R6 random dpacc readback", dout, 64'(exp_dp));
                    exp_dp = w[DW-1:0];
                end
                2: begin
                    shift_ir(4'hB, irc);
                    shift_dr(DW, w, dout, en);
                    check(dout === 64'(exp_ap), "R6 random apacc readback", dout, 64'(exp_ap));
                    exp_ap = w[DW-1:0];
                end
                default: begin
                    shift_ir(kind == 3 ? 4'hF : unimpl[$urandom() % 8], irc);
                    n = 1 + int'($urandom() % 40);
                    din = rnd64() & mask_of(n);
                    shift_dr(n, din, dout, en);
                    check(dout === bypass_exp(n, din), "R4 random bypass", dout, bypass_exp(n, din));
                end
            endcase
            check(irc === 4'b0001, "R3 random IR capture", 64'(irc), 64'd1);
        end

        // R2 reset in the middle of a debug-port scan
        shift_ir(4'hA, irc);
        clk1(1, 0, s, e); clk1(0, 0, s, e); clk1(0, 0, s, e);
        for (int i = 0; i < 5; i++) clk1(0, 1, s, e);
        #1 trst_n = 1'b0;
        #2;
        check(tdo_en === 1'b0 && tdo === 1'b0, "R2 mid-scan reset tdo idle", 64'({tdo_en, tdo}), 64'd0);
        check(dpacc_upd === '0 && apacc_upd === '0, "R2 mid-scan reset clears", 64'(dpacc_upd), 64'd0);
        #3 trst_n = 1'b1;
        clk1(0, 0, s, e);
        shift_dr(32, 64'd0, dout, en);
        check(dout[31:0] === ID_VAL, "R2 IR back to IDCODE", dout, 64'(ID_VAL));

        // R1 random walks, then five ones, then identifier readout
        for (int it = 0; it < 8; it++) begin
            n = int'($urandom() % 40);
            for (int i = 0; i < n; i++) clk1($urandom() % 2 == 1, $urandom() % 2 == 1, s, e);
            for (int i = 0; i < 5; i++) clk1(1, 0, s, e);
            clk1(0, 0, s, e);
            shift_dr(32, 64'd0, dout, en);
            check(dout[31:0] === ID_VAL, "R1 five ones reach reset", dout, 64'(ID_VAL));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule